// File: doc/BRIEF.md
# Scan-Chain Work Register Bank

This block is a register bank that a host reaches through a user data register of the device's test access port. The host shifts scans in over TDI. A scan either writes a 32-bit word to one of the bank's addresses or selects an address for readback. Every scan carries a direction flag and an odd-parity bit, and a scan that fails the check is thrown away. The bank holds the work words that feed a hashing core: eight midstate words and three header words. It also holds a clock setting. Writing the last header word fires a one-cycle job-start strobe.

Results travel the other way. The core pushes found nonces into a 16-entry FIFO. The host reads them back by selecting the pop address and then shifting out 32 bits. Each completed readback removes exactly one entry. When the FIFO is empty the readback returns all ones, which the host treats as "nothing left".

The bank runs on the test clock. Nonce pushes from the core are taken as synchronous to that clock. The tap controller that produces the shift and update controls lives outside the block.

Top module: `scan_regbank`

## Requirements
- R1: While `sel_user` is low, `shift_dr` and `update_dr` have no effect: no register changes, no strobe and no readback load.
- R2: A write scan is 38 bits, shifted first to last as data[0..31], addr[0..3], a flag of 1, then parity. When `update_dr` rises on such a scan, the addressed register takes the data word.
- R3: A scan is accepted only if the XOR of all its bits, parity included, is 1. A failing scan causes no write, no readback load, no job strobe and no FIFO pop.
- R4: A scan is decoded only if exactly 38 bits (write) or exactly 6 bits (read select) were shifted since the last update. Any other length is ignored.
- R5: Addresses 1 to 8 are midstate words 0 to 7. On `midstate`, word k sits at bits [32k+31:32k]. Addresses 9 to 11 are header words 0 to 2 on `header`, laid out the same way. An accepted write to address 11 drives `job_start` high for exactly the one cycle after the update edge.
- R6: Address 13 is the clock setting in MHz, 190 after reset. A write is taken only if the word is even and lies between 2 and 250. Any other write leaves the setting unchanged. Readback returns the value zero-extended.
- R7: A read-select scan is 6 bits: addr[0..3], a flag of 0, then parity. The next 32 shifts present the addressed word on `tdo`, least significant bit first, with each bit valid before the clock edge that shifts it out. Addresses 0, 12 and 15 read as zero.
- R8: Reading address 14 returns the oldest FIFO entry and removes it on the 32nd shift after the select, exactly once. When the FIFO is empty the read returns 0xFFFFFFFF and removes nothing.
- R9: The FIFO keeps up to 16 nonces in arrival order. A push while it is full drops the new nonce and sets `fifo_overflow`, which stays set until reset.
- R10: After reset all work words read as zero, `job_start` and `fifo_overflow` are low, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_user | input | 1 | High while the user register instruction is loaded |
| shift_dr | input | 1 | Tap controller is shifting the data register |
| update_dr | input | 1 | Tap controller is updating the data register |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial readback output |
| push_valid | input | 1 | Core presents a nonce this cycle |
| push_nonce | input | 32 | Nonce from the core |
| midstate | output | 256 | Eight midstate words, word 0 in the low bits |
| header | output | 96 | Three header words, word 0 in the low bits |
| clk_mhz | output | 8 | Current clock setting in MHz |
| job_start | output | 1 | One-cycle pulse after the last header word is written |
| fifo_overflow | output | 1 | Sticky flag: a nonce was dropped on a full FIFO |

## Verification
The checker watches on every cycle that:
- nothing moves while the user instruction is deselected;
- a job strobe always follows an update;
- the clock setting stays even and inside its range, and changes only on updates;
- a pop happens only during a selected shift and never on an empty FIFO;
- the FIFO level stays bounded, and the overflow flag rises only after a push into a full FIFO and never falls.

The bench's scenarios show the rest, which needs whole scans to observe:
- the serial bit order and address map;
- rejection of scans with bad parity or the wrong length;
- the clock-range filter;
- arrival-order readout, the all-ones sentinel and exactly one pop per read.

// File: rtl/scanreg_pkg.sv
package scanreg_pkg;

  localparam int ADDR_W = 4;

  typedef logic [ADDR_W-1:0] reg_addr_t;

  // Addresses the host software relies on
  localparam reg_addr_t A_CLK = 4'd13;
  localparam reg_addr_t A_POP = 4'd14;

  typedef enum logic [1:0] {
    SCAN_NONE   = 2'd0,
    SCAN_WRITE  = 2'd1,
    SCAN_RDADDR = 2'd2
  } scan_kind_e;

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/scan_shifter.sv
module scan_shifter import scanreg_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int AW     = ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                upd_en,
  input  logic                tdi,
  output scan_kind_e          kind,
  output logic [AW-1:0]       scan_addr,
  output logic [DATA_W-1:0]   scan_data,
  output logic [$clog2(DATA_W+AW+4)-1:0] scan_cnt
);
  localparam int SCAN_W  = DATA_W + AW + 2;
  localparam int RD_W    = AW + 2;
  localparam int CNT_W   = $clog2(SCAN_W + 2);
  localparam int CNT_SAT = SCAN_W + 1;
  localparam int FLAG_B  = SCAN_W - 2;

  logic [SCAN_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              par_long, par_short, dir_flag;

  // Next state: bits enter at the top, so the first bit lands at bit 0
  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (shift_en) begin
      sr_d = {tdi, sr_q[SCAN_W-1:1]};
      if (cnt_q != CNT_W'(CNT_SAT)) cnt_d = cnt_q + 1'b1;
    end else if (upd_en) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  // A short select scan occupies the top RD_W bits, at the same field positions
  assign par_long  = ^sr_q;
  assign par_short = ^sr_q[SCAN_W-1:DATA_W];
  assign dir_flag  = sr_q[FLAG_B];

  always_comb begin
    kind = SCAN_NONE;
    if (upd_en) begin
      if (cnt_q == CNT_W'(SCAN_W) && dir_flag && par_long)
        kind = SCAN_WRITE;
      else if (cnt_q == CNT_W'(RD_W) && !dir_flag && par_short)
        kind = SCAN_RDADDR;
    end
  end

  assign scan_addr = sr_q[DATA_W +: AW];
  assign scan_data = sr_q[DATA_W-1:0];
  assign scan_cnt  = cnt_q;
endmodule

// File: rtl/reg_store.sv
module reg_store import scanreg_pkg::*; #(
  parameter int DATA_W  = 32,
  parameter int NUM_MID = 8,
  parameter int NUM_HDR = 3,
  parameter int CLK_W   = 8,
  parameter int CLK_MIN = 2,
  parameter int CLK_MAX = 250,
  parameter int CLK_DEF = 190
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  reg_addr_t                 wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  reg_addr_t                 rd_addr,
  output logic [DATA_W-1:0]         rd_word,
  output logic [NUM_MID*DATA_W-1:0] midstate,
  output logic [NUM_HDR*DATA_W-1:0] header,
  output logic [CLK_W-1:0]          clk_mhz,
  output logic                      job_start
);
  localparam int NUM_WORK = NUM_MID + NUM_HDR;
  localparam reg_addr_t JOB_ADDR = reg_addr_t'(NUM_WORK);

  logic [NUM_WORK*DATA_W-1:0] work_flat;
  logic [CLK_W-1:0]           clk_q, clk_d;
  logic                       job_q, job_d;
  logic                       clk_legal;

  // One word register per work address (addresses start at 1)
  for (genvar g = 0; g < NUM_WORK; g++) begin : g_word
    logic              hit;
    logic [DATA_W-1:0] word_q, word_d;

    assign hit = wr_en && (wr_addr == reg_addr_t'(g + 1));

    always_comb begin
      word_d = word_q;
      if (hit) word_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign work_flat[g*DATA_W +: DATA_W] = word_q;
  end

  assign clk_legal = !wr_data[0]
                  && (wr_data >= DATA_W'(CLK_MIN))
                  && (wr_data <= DATA_W'(CLK_MAX));

  always_comb begin
    clk_d = clk_q;
    if (wr_en && wr_addr == A_CLK && clk_legal) clk_d = wr_data[CLK_W-1:0];
    job_d = wr_en && (wr_addr == JOB_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= CLK_W'(CLK_DEF);
      job_q <= 1'b0;
    end else begin
      clk_q <= clk_d;
      job_q <= job_d;
    end
  end

  // Readback mux for everything except the pop address
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_WORK; i++) begin
      if (rd_addr == reg_addr_t'(i + 1)) rd_word = work_flat[i*DATA_W +: DATA_W];
    end
    if (rd_addr == A_CLK) rd_word = {{(DATA_W-CLK_W){1'b0}}, clk_q};
  end

  assign midstate  = work_flat[NUM_MID*DATA_W-1:0];
  assign header    = work_flat[NUM_WORK*DATA_W-1:NUM_MID*DATA_W];
  assign clk_mhz   = clk_q;
  assign job_start = job_q;
endmodule

// File: rtl/nonce_fifo.sv
module nonce_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_en,
  input  logic [DATA_W-1:0]        push_data,
  input  logic                     pop_en,
  output logic [DATA_W-1:0]        head,
  output logic                     empty,
  output logic                     full,
  output logic                     overflow,
  output logic [$clog2(DEPTH):0]   level
);
  // DEPTH must be a power of two: pointers carry one wrap bit
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W:0]    wr_q, wr_d, rd_q, rd_d;
  logic              ovf_q, ovf_d;
  logic              accept;

  assign empty  = (wr_q == rd_q);
  assign full   = (wr_q[PTR_W] != rd_q[PTR_W]) && (wr_q[PTR_W-1:0] == rd_q[PTR_W-1:0]);
  assign accept = push_en && !full;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    ovf_d = ovf_q;
    if (accept)          wr_d  = wr_q + 1'b1;
    if (push_en && full) ovf_d = 1'b1;
    if (pop_en && !empty) rd_d = rd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      ovf_q <= ovf_d;
    end
  end

  // Storage carries no reset; only accepted pushes write it
  always_ff @(posedge clk) begin
    if (accept) mem_q[wr_q[PTR_W-1:0]] <= push_data;
  end

  assign head     = mem_q[rd_q[PTR_W-1:0]];
  assign overflow = ovf_q;
  assign level    = wr_q - rd_q;
endmodule

// File: rtl/scan_regbank.sv
module scan_regbank import scanreg_pkg::*; #(
  parameter int DATA_W     = 32,
  parameter int NUM_MID    = 8,
  parameter int NUM_HDR    = 3,
  parameter int FIFO_DEPTH = 16,
  parameter int CLK_W      = 8,
  parameter int CLK_MIN    = 2,
  parameter int CLK_MAX    = 250,
  parameter int CLK_DEF    = 190
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel_user,
  input  logic                      shift_dr,
  input  logic                      update_dr,
  input  logic                      tdi,
  output logic                      tdo,
  input  logic                      push_valid,
  input  logic [DATA_W-1:0]         push_nonce,
  output logic [NUM_MID*DATA_W-1:0] midstate,
  output logic [NUM_HDR*DATA_W-1:0] header,
  output logic [CLK_W-1:0]          clk_mhz,
  output logic                      job_start,
  output logic                      fifo_overflow
);
  localparam int SCAN_W = DATA_W + ADDR_W + 2;
  localparam int CNT_W  = $clog2(SCAN_W + 2);
  localparam int LVL_W  = $clog2(FIFO_DEPTH) + 1;

  logic              rst_sync_n;
  logic              shift_en, upd_en;
  scan_kind_e        kind;
  reg_addr_t         scan_addr;
  logic [DATA_W-1:0] scan_data;
  logic [CNT_W-1:0]  scan_cnt;
  logic [DATA_W-1:0] rd_word, fifo_head;
  logic              fifo_empty, fifo_full, fifo_pop;
  logic [LVL_W-1:0]  fifo_level;
  logic [DATA_W-1:0] out_q, out_d;
  logic              armed_q, armed_d;

  rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  assign shift_en = sel_user && shift_dr;
  assign upd_en   = sel_user && update_dr;

  scan_shifter #(.DATA_W(DATA_W), .AW(ADDR_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .shift_en  (shift_en),
    .upd_en    (upd_en),
    .tdi       (tdi),
    .kind      (kind),
    .scan_addr (scan_addr),
    .scan_data (scan_data),
    .scan_cnt  (scan_cnt)
  );

  reg_store #(
    .DATA_W (DATA_W), .NUM_MID (NUM_MID), .NUM_HDR (NUM_HDR), .CLK_W (CLK_W),
    .CLK_MIN (CLK_MIN), .CLK_MAX (CLK_MAX), .CLK_DEF (CLK_DEF)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (kind == SCAN_WRITE),
    .wr_addr   (scan_addr),
    .wr_data   (scan_data),
    .rd_addr   (scan_addr),
    .rd_word   (rd_word),
    .midstate  (midstate),
    .header    (header),
    .clk_mhz   (clk_mhz),
    .job_start (job_start)
  );

  nonce_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_en   (push_valid),
    .push_data (push_nonce),
    .pop_en    (fifo_pop),
    .head      (fifo_head),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .overflow  (fifo_overflow),
    .level     (fifo_level)
  );

  // Pop on the shift that moves the last readback bit out
  assign fifo_pop = shift_en && armed_q && (scan_cnt == CNT_W'(DATA_W - 1));

  always_comb begin
    out_d   = out_q;
    armed_d = armed_q;
    if (shift_en) begin
      out_d = {1'b0, out_q[DATA_W-1:1]};
      if (fifo_pop) armed_d = 1'b0;
    end else if (kind == SCAN_RDADDR) begin
      if (scan_addr == A_POP) begin
        out_d   = fifo_empty ? '1 : fifo_head;
        armed_d = !fifo_empty;
      end else begin
        out_d   = rd_word;
        armed_d = 1'b0;
      end
    end else if (upd_en) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      out_q   <= out_d;
      armed_q <= armed_d;
    end
  end

  assign tdo = out_q[0];
endmodule

// File: rtl/scanreg_checker.sv
module scanreg_checker #(
  parameter int DATA_W     = 32,
  parameter int NUM_MID    = 8,
  parameter int NUM_HDR    = 3,
  parameter int FIFO_DEPTH = 16,
  parameter int CLK_W      = 8,
  parameter int CLK_MIN    = 2,
  parameter int CLK_MAX    = 250
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         sel_user,
  input logic                         shift_dr,
  input logic                         update_dr,
  input logic                         push_valid,
  input logic [NUM_MID*DATA_W-1:0]    midstate,
  input logic [NUM_HDR*DATA_W-1:0]    header,
  input logic [CLK_W-1:0]             clk_mhz,
  input logic                         job_start,
  input logic                         fifo_overflow,
  input logic                         pop_en,
  input logic                         fifo_empty,
  input logic                         fifo_full,
  input logic [$clog2(FIFO_DEPTH):0]  fifo_level
);
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

  // R1: a deselected register path leaves every output untouched
  a_r1_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_user |=> ($stable(midstate) && $stable(header) && $stable(clk_mhz) && !job_start));

  // R5: the job strobe is always the echo of a selected update
  a_r5_job_follows_update: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |-> $past(update_dr && sel_user));

  // R6: the clock setting never leaves its legal set
  a_r6_clk_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_mhz[0] && clk_mhz >= CLK_W'(CLK_MIN) && clk_mhz <= CLK_W'(CLK_MAX)));

  // R6: the clock setting moves only on a selected update
  a_r6_clk_only_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    !(update_dr && sel_user) |=> $stable(clk_mhz));

  // R8: a pop is made only on a selected shift
  a_r8_pop_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (shift_dr && sel_user));

  // R8: an empty FIFO is never popped
  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> !fifo_empty);

  // R9: the level never exceeds the capacity
  a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(FIFO_DEPTH));

  // R9: the overflow flag is sticky
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_overflow |=> fifo_overflow);

  // R9: the overflow flag rises only after a push into a full FIFO
  a_r9_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_overflow) |-> $past(push_valid && fifo_full));
endmodule

bind scan_regbank scanreg_checker #(
  .DATA_W (DATA_W), .NUM_MID (NUM_MID), .NUM_HDR (NUM_HDR), .FIFO_DEPTH (FIFO_DEPTH),
  .CLK_W (CLK_W), .CLK_MIN (CLK_MIN), .CLK_MAX (CLK_MAX)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .sel_user      (sel_user),
  .shift_dr      (shift_dr),
  .update_dr     (update_dr),
  .push_valid    (push_valid),
  .midstate      (midstate),
  .header        (header),
  .clk_mhz       (clk_mhz),
  .job_start     (job_start),
  .fifo_overflow (fifo_overflow),
  .pop_en        (fifo_pop),
  .fifo_empty    (fifo_empty),
  .fifo_full     (fifo_full),
  .fifo_level    (fifo_level)
);

// File: tb/scan_regbank_tb_top.sv
module scan_regbank_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_user = 1'b1;
  logic         shift_dr = 1'b0;
  logic         update_dr = 1'b0;
  logic         tdi = 1'b0;
  logic         tdo;
  logic         push_valid = 1'b0;
  logic [31:0]  push_nonce = '0;
  logic [255:0] midstate;
  logic [95:0]  header;
  logic [7:0]   clk_mhz;
  logic         job_start;
  logic         fifo_overflow;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  scan_regbank dut_i (
    .clk (clk), .rst_n (rst_n), .sel_user (sel_user), .shift_dr (shift_dr),
    .update_dr (update_dr), .tdi (tdi), .tdo (tdo), .push_valid (push_valid),
    .push_nonce (push_nonce), .midstate (midstate), .header (header),
    .clk_mhz (clk_mhz), .job_start (job_start), .fifo_overflow (fifo_overflow)
  );

  // {write?, address, data-or-expected}
  localparam int NVEC = 15;
  localparam logic [36:0] VECS [NVEC] = '{
    {1'b1, 4'h1, 32'hA5A5_0001},
    {1'b1, 4'h4, 32'h0000_0404},
    {1'b1, 4'h8, 32'h8888_0008},
    {1'b1, 4'h9, 32'h9999_0009},
    {1'b1, 4'hA, 32'h1010_1010},
    {1'b1, 4'hD, 32'h0000_0064},
    {1'b0, 4'h1, 32'hA5A5_0001},
    {1'b0, 4'h4, 32'h0000_0404},
    {1'b0, 4'h8, 32'h8888_0008},
    {1'b0, 4'h9, 32'h9999_0009},
    {1'b0, 4'hA, 32'h1010_1010},
    {1'b0, 4'hD, 32'h0000_0064},
    {1'b0, 4'h0, 32'h0000_0000},
    {1'b0, 4'hC, 32'h0000_0000},
    {1'b0, 4'hF, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [37:0] wr_bits(input logic [3:0] a, input logic [31:0] d, input bit flip);
    logic [37:0] b;
    b[31:0]  = d;
    b[35:32] = a;
    b[36]    = 1'b1;
    b[37]    = 1'b1 ^ (^b[36:0]) ^ flip;
    return b;
  endfunction

  function automatic logic [37:0] rd_bits(input logic [3:0] a, input bit flip);
    logic [37:0] b;
    b       = '0;
    b[3:0]  = a;
    b[4]    = 1'b0;
    b[5]    = 1'b1 ^ (^b[4:0]) ^ flip;
    return b;
  endfunction

  // Shift n bits, capturing tdo before each shifting edge, then update
  task automatic scan(input logic [37:0] bits, input int n, input logic sel,
                      output logic [31:0] got, output logic job);
    got = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i < 32) got[i] = tdo;
      sel_user = sel;
      tdi      = bits[i];
      shift_dr = 1'b1;
    end
    @(negedge clk);
    shift_dr  = 1'b0;
    update_dr = 1'b1;
    @(negedge clk);
    job       = job_start;
    update_dr = 1'b0;
    sel_user  = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output logic job);
    logic [31:0] g;
    scan(wr_bits(a, d, 1'b0), 38, 1'b1, g, job);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    logic j;
    logic [31:0] g;
    scan(rd_bits(a, 1'b0), 6, 1'b1, g, j);
    scan('0, 32, 1'b1, v, j);
  endtask

  task automatic push(input logic [31:0] v);
    @(negedge clk);
    push_valid = 1'b1;
    push_nonce = v;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v, g;
    logic        j;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 / R6: reset state
    check("R10 midstate word0 after reset", midstate[31:0], 32'h0);
    check("R10 header word2 after reset", header[95:64], 32'h0);
    check("R10 job_start low", {31'h0, job_start}, 32'h0);
    check("R10 overflow low", {31'h0, fifo_overflow}, 32'h0);
    check("R6 clock default", {24'h0, clk_mhz}, 32'd190);
    rd(4'hE, v);
    check("R8 empty pop sentinel", v, 32'hFFFF_FFFF);

    // Table walk: writes then readbacks (R2, R7)
    for (int k = 0; k < NVEC; k++) begin
      if (VECS[k][36]) begin
        wr(VECS[k][35:32], VECS[k][31:0], j);
      end else begin
        rd(VECS[k][35:32], v);
        check($sformatf("R7 table entry %0d", k), v, VECS[k][31:0]);
      end
    end
    check("R2 midstate word0 port", midstate[31:0], 32'hA5A5_0001);
    check("R5 midstate word7 position", midstate[255:224], 32'h8888_0008);
    check("R5 header word1 position", header[63:32], 32'h1010_1010);
    check("R6 clock port after write", {24'h0, clk_mhz}, 32'd100);

    // R5: job strobe only for the last header word
    wr(4'hA, 32'h1111_2222, j);
    check("R5 no strobe on address 10", {31'h0, j}, 32'h0);
    wr(4'hB, 32'hCAFE_F00D, j);
    check("R5 strobe on address 11", {31'h0, j}, 32'h1);
    @(negedge clk);
    check("R5 strobe lasts one cycle", {31'h0, job_start}, 32'h0);
    check("R5 header word2 port", header[95:64], 32'hCAFE_F00D);

    // R3: bad parity write is dropped, including a job write
    scan(wr_bits(4'h4, 32'hDEAD_0000, 1'b1), 38, 1'b1, g, j);
    rd(4'h4, v);
    check("R3 bad parity write ignored", v, 32'h0000_0404);
    scan(wr_bits(4'hB, 32'h0BAD_0BAD, 1'b1), 38, 1'b1, g, j);
    check("R3 bad parity no strobe", {31'h0, j}, 32'h0);
    check("R3 bad parity header unchanged", header[95:64], 32'hCAFE_F00D);

    // R4: wrong scan length is dropped
    scan(wr_bits(4'h4, 32'h7777_7777, 1'b0), 37, 1'b1, g, j);
    rd(4'h4, v);
    check("R4 short write scan ignored", v, 32'h0000_0404);

    // R1: deselected scan has no effect
    scan(wr_bits(4'h4, 32'h5555_5555, 1'b0), 38, 1'b0, g, j);
    check("R1 deselected write no strobe", {31'h0, j}, 32'h0);
    rd(4'h4, v);
    check("R1 deselected write ignored", v, 32'h0000_0404);

    // R6: clock range filter
    wr(4'hD, 32'd251, j);
    check("R6 odd clock rejected", {24'h0, clk_mhz}, 32'd100);
    wr(4'hD, 32'd252, j);
    check("R6 high clock rejected", {24'h0, clk_mhz}, 32'd100);
    wr(4'hD, 32'd0, j);
    check("R6 zero clock rejected", {24'h0, clk_mhz}, 32'd100);
    wr(4'hD, 32'h0001_0064, j);
    check("R6 wide clock rejected", {24'h0, clk_mhz}, 32'd100);
    wr(4'hD, 32'd2, j);
    check("R6 minimum clock taken", {24'h0, clk_mhz}, 32'd2);
    wr(4'hD, 32'd250, j);
    rd(4'hD, v);
    check("R6 maximum clock readback", v, 32'd250);

    // R8: order, single pop per read, bad parity select does not pop
    push(32'h0000_A001);
    push(32'h0000_A002);
    push(32'h0000_A003);
    scan(rd_bits(4'hE, 1'b1), 6, 1'b1, g, j);
    scan('0, 32, 1'b1, g, j);
    rd(4'hE, v);
    check("R8 first nonce after bad select", v, 32'h0000_A001);
    rd(4'hE, v);
    check("R8 second nonce", v, 32'h0000_A002);
    rd(4'hE, v);
    check("R8 third nonce", v, 32'h0000_A003);
    rd(4'hE, v);
    check("R8 sentinel after drain", v, 32'hFFFF_FFFF);

    // R9: fill past capacity
    for (int k = 0; k < 17; k++) begin
      @(negedge clk);
      push_valid = 1'b1;
      push_nonce = 32'h0000_1000 + k;
    end
    @(negedge clk);
    push_valid = 1'b0;
    check("R9 overflow set", {31'h0, fifo_overflow}, 32'h1);
    for (int k = 0; k < 16; k++) begin
      rd(4'hE, v);
      check($sformatf("R9 fifo entry %0d", k), v, 32'h0000_1000 + k);
    end
    rd(4'hE, v);
    check("R9 dropped nonce absent", v, 32'hFFFF_FFFF);
    check("R9 overflow sticky", {31'h0, fifo_overflow}, 32'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule